// File: doc/BRIEF.md
# Decode-Stage Control-Flow Resolver

This block settles conditional branches and unconditional jumps while the instruction is still in the decode stage of a five-stage pipeline. It takes the decoded transfer kind, the two register-file read values, the decode-stage PC, the sign-extended immediate and the destination register index. A dedicated subtract comparator produces a zero flag and the sign bit of `rs1 - rs2`, and these two signals decide whether a branch is taken. In the same cycle the block forms the transfer target and raises the PC source select.

A taken transfer leaves exactly one wrong-path instruction behind it: the one already fetched. The block owns the fetch/decode instruction register, and on a taken transfer it loads that register with the canonical nop (`add x0,x0,x0`) instead of the fetched word. For jumps it also presents the return address (PC+4) and a write enable for the writeback path. That write enable is suppressed when the destination is x0.

Top module: `cf_resolver`

## Requirements
- R1: `pc_sel` and `flush` are high in the same cycle, and only in a cycle where the current transfer is taken.
- R2: Kind code 1 (equal-branch) is taken when `rs1_val - rs2_val` is zero. Kind code 2 (not-equal-branch) is taken when that difference is non-zero.
- R3: Kind code 3 (less-than branch) is taken when bit 31 of `rs1_val - rs2_val` is 1. Kind code 4 (greater-or-equal branch) is taken when that bit is 0.
- R4: For kind codes 1 to 5, `target` equals `dec_pc + dec_imm`. Kind code 5 (direct jump) is always taken.
- R5: Kind code 6 (register jump) is always taken, and `target` equals `(rs1_val + dec_imm)` with bit 0 forced to 0.
- R6: `link_addr` equals `dec_pc + 4`. `link_wen` is 1 only for kind codes 5 and 6 with `dec_rd` non-zero.
- R7: Kind codes 0 and 7 are not transfers: `pc_sel`, `flush` and `link_wen` stay 0.
- R8: If a transfer is taken at a rising clock edge, `ifid_instr` becomes 32'h00000033 after that edge, whatever the value of `fetch_adv`.
- R9: With no taken transfer, `ifid_instr` loads `fetch_instr` at an edge where `fetch_adv` is 1, and holds its value where `fetch_adv` is 0.
- R10: While `rst_n` is low, `ifid_instr` is 32'h00000033.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_op | input | 3 | Transfer kind: 0 none, 1 eq, 2 ne, 3 lt, 4 ge, 5 direct jump, 6 register jump, 7 none |
| dec_pc | input | 32 | PC of the decode-stage instruction |
| dec_imm | input | 32 | Sign-extended immediate |
| rs1_val | input | 32 | First register-file read value |
| rs2_val | input | 32 | Second register-file read value |
| dec_rd | input | 5 | Destination register index |
| fetch_instr | input | 32 | Instruction word from fetch |
| fetch_adv | input | 1 | Enable for the fetch/decode register |
| pc_sel | output | 1 | 1: next PC from `target`; 0: sequential PC |
| target | output | 32 | Branch or jump target |
| flush | output | 1 | Taken-transfer pulse that squashes the fetched instruction |
| ifid_instr | output | 32 | Fetch/decode register contents |
| link_addr | output | 32 | Return address for writeback |
| link_wen | output | 1 | Writeback enable for the return address |

## Verification
The checker watches several properties on every cycle. It checks that a flush is always followed by a nop in the fetch/decode register and that the register holds when it is neither enabled nor flushed. It checks that jumps always select the target and that a register-jump target is always even. It also checks that a link write never targets x0 and that non-transfer codes never redirect. The bench checks the comparator decisions through a vector table of equal, unequal and negative operands. It covers the exact target and return-address arithmetic, and shows that a flush takes priority over a stalled fetch enable.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int INSN_W = 32;
  localparam logic [INSN_W-1:0] NOP_WORD = 32'h0000_0033;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_EQ   = 3'd1,
    K_NE   = 3'd2,
    K_LT   = 3'd3,
    K_GE   = 3'd4,
    K_JD   = 3'd5,
    K_JR   = 3'd6,
    K_RSV  = 3'd7
  } xfer_kind_t;
endpackage

// File: rtl/cfr_compare.sv
module cfr_compare #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  output logic            is_zero,
  output logic            is_neg
);
  logic [XLEN-1:0] diff;

  always_comb begin
    diff    = lhs - rhs;
    is_zero = (diff == '0);
    is_neg  = diff[XLEN-1];
  end
endmodule

// File: rtl/cfr_target.sv
module cfr_target #(
  parameter int XLEN      = 32,
  parameter bit CLEAR_LSB = 1'b1
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] base_reg,
  input  logic            use_reg,
  output logic [XLEN-1:0] tgt,
  output logic [XLEN-1:0] ret_addr
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_rel;
  logic [XLEN-1:0] reg_sum;
  logic [XLEN-1:0] reg_rel;

  always_comb begin
    pc_rel   = pc + imm;
    reg_sum  = base_reg + imm;
    ret_addr = pc + STEP;
  end

  generate
    if (CLEAR_LSB) begin : g_clr
      assign reg_rel = {reg_sum[XLEN-1:1], 1'b0};
    end else begin : g_raw
      assign reg_rel = reg_sum;
    end
  endgenerate

  assign tgt = use_reg ? reg_rel : pc_rel;
endmodule

// File: rtl/cfr_ifid.sv
module cfr_ifid
  import cfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              squash,
  input  logic              load_en,
  input  logic [INSN_W-1:0] din,
  output logic [INSN_W-1:0] q
);
  logic [INSN_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (squash)       q_nxt = NOP_WORD;
    else if (load_en) q_nxt = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= NOP_WORD;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/cf_resolver.sv
module cf_resolver
  import cfr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        dec_op,
  input  logic [XLEN-1:0]   dec_pc,
  input  logic [XLEN-1:0]   dec_imm,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [XLEN-1:0]   rs2_val,
  input  logic [RW-1:0]     dec_rd,
  input  logic [INSN_W-1:0] fetch_instr,
  input  logic              fetch_adv,
  output logic              pc_sel,
  output logic [XLEN-1:0]   target,
  output logic              flush,
  output logic [INSN_W-1:0] ifid_instr,
  output logic [XLEN-1:0]   link_addr,
  output logic              link_wen
);
  xfer_kind_t kind;
  logic       cmp_zero;
  logic       cmp_neg;
  logic       taken;
  logic       is_jump;

  assign kind = xfer_kind_t'(dec_op);

  cfr_compare #(.XLEN(XLEN)) u_cmp (
    .lhs     (rs1_val),
    .rhs     (rs2_val),
    .is_zero (cmp_zero),
    .is_neg  (cmp_neg)
  );

  cfr_target #(.XLEN(XLEN), .CLEAR_LSB(1'b1)) u_tgt (
    .pc       (dec_pc),
    .imm      (dec_imm),
    .base_reg (rs1_val),
    .use_reg  (kind == K_JR),
    .tgt      (target),
    .ret_addr (link_addr)
  );

  always_comb begin
    is_jump = 1'b0;
    taken   = 1'b0;
    case (kind)
      K_EQ: taken = cmp_zero;
      K_NE: taken = !cmp_zero;
      K_LT: taken = cmp_neg;
      K_GE: taken = !cmp_neg;
      K_JD, K_JR: begin
        is_jump = 1'b1;
        taken   = 1'b1;
      end
      default: taken = 1'b0;
    endcase
  end

  assign pc_sel   = taken;
  assign flush    = taken;
  assign link_wen = is_jump && (dec_rd != '0);

  cfr_ifid u_ifid (
    .clk     (clk),
    .rst_n   (rst_n),
    .squash  (flush),
    .load_en (fetch_adv),
    .din     (fetch_instr),
    .q       (ifid_instr)
  );
endmodule

// File: rtl/cfr_chk.sv
module cfr_chk
  import cfr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        dec_op,
  input logic [XLEN-1:0]   rs1_val,
  input logic [XLEN-1:0]   rs2_val,
  input logic [RW-1:0]     dec_rd,
  input logic              fetch_adv,
  input logic              pc_sel,
  input logic [XLEN-1:0]   target,
  input logic              flush,
  input logic [INSN_W-1:0] ifid_instr,
  input logic              link_wen
);
  // R8
  flush_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ifid_instr == NOP_WORD);

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !fetch_adv) |=> $stable(ifid_instr));

  // R4
  jump_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_op == 3'd5) |-> (pc_sel && flush));

  // R5
  jump_reg_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_op == 3'd6) |-> (pc_sel && !target[0]));

  // R6
  link_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_wen |-> (dec_rd != '0 && (dec_op == 3'd5 || dec_op == 3'd6)));

  // R7
  none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_op == 3'd0 || dec_op == 3'd7) |-> (!pc_sel && !flush && !link_wen));

  // R2
  eq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_op == 3'd1 && rs1_val == rs2_val) |-> pc_sel);

  // R1
  sel_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel == flush);
endmodule

bind cf_resolver cfr_chk #(.XLEN(XLEN), .RW(RW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dec_op     (dec_op),
  .rs1_val    (rs1_val),
  .rs2_val    (rs2_val),
  .dec_rd     (dec_rd),
  .fetch_adv  (fetch_adv),
  .pc_sel     (pc_sel),
  .target     (target),
  .flush      (flush),
  .ifid_instr (ifid_instr),
  .link_wen   (link_wen)
);

// File: tb/cf_resolver_tb.sv
module cf_resolver_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NOP = 32'h0000_0033;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] pc;
    logic [31:0] imm;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  rd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 32'h100, 32'h20,       32'd5,        32'd5, 5'd0},
    '{3'd1, 32'h104, 32'h20,       32'd5,        32'd6, 5'd0},
    '{3'd2, 32'h108, 32'hFFFFFFF0, 32'd5,        32'd6, 5'd0},
    '{3'd2, 32'h10C, 32'h40,       32'd7,        32'd7, 5'd0},
    '{3'd3, 32'h110, 32'h8,        32'hFFFFFFFD, 32'd2, 5'd0},
    '{3'd3, 32'h114, 32'h8,        32'd4,        32'd4, 5'd0},
    '{3'd4, 32'h118, 32'h10,       32'd4,        32'd4, 5'd0},
    '{3'd4, 32'h11C, 32'h10,       32'hFFFFFFF0, 32'd1, 5'd0},
    '{3'd5, 32'h200, 32'hFFFFFFF8, 32'd0,        32'd0, 5'd1},
    '{3'd6, 32'h300, 32'd4,        32'h1001,     32'd0, 5'd31},
    '{3'd6, 32'h304, 32'hFFFFFFFC, 32'h2000,     32'd0, 5'd0},
    '{3'd0, 32'h308, 32'h10,       32'd1,        32'd1, 5'd3}
  };

  logic        clk, rst_n;
  logic [2:0]  dec_op;
  logic [31:0] dec_pc, dec_imm, rs1_val, rs2_val, fetch_instr;
  logic [4:0]  dec_rd;
  logic        fetch_adv;
  logic        pc_sel, flush, link_wen;
  logic [31:0] target, ifid_instr, link_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  cf_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .dec_op(dec_op), .dec_pc(dec_pc),
    .dec_imm(dec_imm), .rs1_val(rs1_val), .rs2_val(rs2_val),
    .dec_rd(dec_rd), .fetch_instr(fetch_instr), .fetch_adv(fetch_adv),
    .pc_sel(pc_sel), .target(target), .flush(flush),
    .ifid_instr(ifid_instr), .link_addr(link_addr), .link_wen(link_wen)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic ref_taken(input logic [2:0] op, input logic [31:0] a,
                                     input logic [31:0] b);
    logic [31:0] d;
    d = a - b;
    case (op)
      3'd1: ref_taken = (d == 0);
      3'd2: ref_taken = (d != 0);
      3'd3: ref_taken = d[31];
      3'd4: ref_taken = !d[31];
      3'd5, 3'd6: ref_taken = 1'b1;
      default: ref_taken = 1'b0;
    endcase
  endfunction

  task automatic apply(input vec_t v, input logic [31:0] fw, input logic adv);
    dec_op = v.op; dec_pc = v.pc; dec_imm = v.imm;
    rs1_val = v.a; rs2_val = v.b; dec_rd = v.rd;
    fetch_instr = fw; fetch_adv = adv;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic        tk;
    logic [31:0] et;
    rst_n = 1'b0;
    apply('0, 32'hDEAD_BEEF, 1'b1);
    @(negedge clk); @(negedge clk);
    check("R10 reset ifid", ifid_instr, NOP);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      apply(v, 32'h1000_0000 + i, 1'b1);
      #1;
      tk = ref_taken(v.op, v.a, v.b);
      check("R1 R2 R3 pc_sel", {31'd0, pc_sel}, {31'd0, tk});
      check("R1 flush", {31'd0, flush}, {31'd0, tk});
      if (v.op == 3'd6) begin
        et = v.a + v.imm; et[0] = 1'b0;
        check("R5 jr target", target, et);
      end else if (v.op >= 3'd1 && v.op <= 3'd5) begin
        check("R4 target", target, v.pc + v.imm);
      end
      check("R6 link_addr", link_addr, v.pc + 32'd4);
      check("R6 R7 link_wen", {31'd0, link_wen},
            {31'd0, (v.op == 3'd5 || v.op == 3'd6) && v.rd != 0});
      @(negedge clk);
      check("R8 R9 ifid", ifid_instr, tk ? NOP : 32'h1000_0000 + i);
    end

    // R9 hold while not enabled
    apply('{3'd0, 32'h0, 32'h0, 32'd0, 32'd0, 5'd0}, 32'hCAFE_0001, 1'b1);
    @(negedge clk);
    apply('{3'd0, 32'h0, 32'h0, 32'd0, 32'd0, 5'd0}, 32'hCAFE_0002, 1'b0);
    @(negedge clk);
    check("R9 hold", ifid_instr, 32'hCAFE_0001);

    // R8 flush overrides disabled fetch enable
    apply('{3'd1, 32'h40, 32'h8, 32'd9, 32'd9, 5'd0}, 32'hCAFE_0003, 1'b0);
    @(negedge clk);
    check("R8 flush with stall", ifid_instr, NOP);

    // R7 reserved code 7 is inert
    apply('{3'd7, 32'h80, 32'h8, 32'd1, 32'd1, 5'd4}, 32'hCAFE_0004, 1'b1);
    #1;
    check("R7 code7 pc_sel", {31'd0, pc_sel}, 32'd0);
    check("R7 code7 link_wen", {31'd0, link_wen}, 32'd0);
    @(negedge clk);
    check("R7 code7 ifid", ifid_instr, 32'hCAFE_0004);

    // R3 negative vs negative, lt taken when difference negative
    apply('{3'd3, 32'h90, 32'h4, 32'hFFFFFFF0, 32'hFFFFFFFF, 5'd0}, 32'hCAFE_0005, 1'b1);
    #1;
    check("R3 neg lt", {31'd0, pc_sel}, 32'd1);
    @(negedge clk);

    // R10 reset asserted mid-run restores nop
    apply('0, 32'hCAFE_0006, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 async reset", ifid_instr, NOP);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule